// File: doc/BRIEF.md
# Vector Coordinate Soft-Processor Core

This core runs small drawing routines that work on three-dimensional coordinates. Program and data storage are kept apart. The 4096-word instruction store sits outside the core. The core presents a 12-bit fetch address and reads a 16-bit word back in the same cycle. Data storage is 256 bytes inside the core. The core is not pipelined: each clock edge retires exactly one instruction, and the next word is fetched only after that.

There are sixteen 8-bit scalar registers and sixteen vector registers. Each vector register packs three 5-bit lanes: lane 0 in bits [4:0], lane 1 in [9:5] and lane 2 in [14:10]. Vector add and subtract treat each lane as its own number. Move instructions copy values between a scalar register and a single lane. A registered commit port reports every register write one cycle after the instruction executes, so the surrounding logic can follow the program's results.

Every instruction carries its opcode in bits [15:12]. The register format puts fields d, a and b in [11:8], [7:4] and [3:0]. The immediate format puts d in [11:8] and an 8-bit value in [7:0]. The jump format puts a 12-bit absolute target in [11:0]. In the requirements below, S[n] is a scalar register and V[n] is a vector register.

Top module: `vec_core`

## Requirements
- R1: While rst_n is low and after it is released, imem_addr is 0, done is 0, ret_valid is 0, and every scalar and vector register reads as zero.
- R2: Each clock edge executes one instruction. Every instruction that is not a jump, a taken branch or a halt moves the PC to PC+1. Opcodes 0xC to 0xF are no-ops that only advance the PC.
- R3: Opcode 0x1 sets S[d]=S[a]+S[b] and opcode 0x2 sets S[d]=S[a]-S[b], both modulo 256. Opcode 0x3 loads the 8-bit immediate into S[d].
- R4: Opcode 0x4 loads S[d] from data byte S[a]. Opcode 0x5 stores S[d] into data byte S[a].
- R5: Opcode 0x6 sets V[d]=V[a]+V[b] and opcode 0x7 sets V[d]=V[a]-V[b]. Each lane wraps modulo 32 with no carry or borrow into its neighbour.
- R6: Opcode 0x8 writes S[a][4:0] into lane b[1:0] of V[d] and leaves the other lanes unchanged. A lane code of 3 writes nothing.
- R7: Opcode 0x9 sets S[d] to lane b[1:0] of V[a], zero-extended. A lane code of 3 yields 0.
- R8: Opcode 0xA loads the PC with the 12-bit target in bits [11:0].
- R9: Opcode 0xB tests S[d]. If it is zero, the PC becomes {PC[11:8], imm8}. Otherwise the PC becomes PC+1.
- R10: Opcode 0x0 halts the core. The PC freezes, done rises one cycle later, and done stays high until reset.
- R11: After each instruction that writes a register, ret_valid is 1 for one cycle. In that cycle ret_vec tells vector from scalar, ret_rd gives the register and ret_val gives the value written (a scalar value is zero-extended). Stores, jumps, branches, no-ops and halts give ret_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 12 | Fetch address (the PC) |
| imem_data | input | 16 | Instruction word at imem_addr, valid in the same cycle |
| done | output | 1 | Core has halted |
| ret_valid | output | 1 | A register write retired last cycle |
| ret_vec | output | 1 | The retired write went to a vector register |
| ret_rd | output | 4 | Destination register of the retired write |
| ret_val | output | 15 | Value written (scalar zero-extended) |

## Verification
A wrong PC appears on imem_addr at the very next edge, because every cycle's fetch address follows directly from the previous instruction. A corrupted register is silent until some later instruction reads it. Its value then shows on ret_val in the cycle after that reader executes. For this reason the program reads back every vector lane and every stored byte soon after writing it, and it runs a second program after reset to show that no register content survives reset.

// File: rtl/vec_core.sv
module vec_core #(
  parameter int DW = 8,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [11:0]   imem_addr,
  input  logic [15:0]   imem_data,
  output logic          done,
  output logic          ret_valid,
  output logic          ret_vec,
  output logic [3:0]    ret_rd,
  output logic [3*LW-1:0] ret_val
);
  localparam int VW    = 3 * LW;
  localparam int PCW   = 12;
  localparam int NREG  = 16;
  localparam int DEPTH = 1 << DW;

  typedef enum logic [3:0] {
    OP_HALT = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_LDI = 4'h3,
    OP_LD   = 4'h4, OP_ST  = 4'h5, OP_VADD = 4'h6, OP_VSUB = 4'h7,
    OP_S2L  = 4'h8, OP_L2S = 4'h9, OP_JMP = 4'hA, OP_JZ = 4'hB
  } op_e;

  logic [PCW-1:0] pc_q, pc_n;
  logic           done_q, halt_n;
  logic [DW-1:0]  sreg [NREG];
  logic [VW-1:0]  vreg [NREG];
  logic [DW-1:0]  dmem [DEPTH];

  op_e        op;
  logic [3:0] f_d, f_a, f_b;
  logic [7:0] imm;
  assign op  = op_e'(imem_data[15:12]);
  assign f_d = imem_data[11:8];
  assign f_a = imem_data[7:4];
  assign f_b = imem_data[3:0];
  assign imm = imem_data[7:0];

  logic [DW-1:0] sa, sb, sd;
  logic [VW-1:0] va, vb, vd;
  assign sa = sreg[f_a];
  assign sb = sreg[f_b];
  assign sd = sreg[f_d];
  assign va = vreg[f_a];
  assign vb = vreg[f_b];
  assign vd = vreg[f_d];

  logic [VW-1:0] vsum, vdif, vins;
  logic [LW-1:0] lane_rd;

  for (genvar l = 0; l < 3; l++) begin : g_lane
    assign vsum[l*LW +: LW] = va[l*LW +: LW] + vb[l*LW +: LW];
    assign vdif[l*LW +: LW] = va[l*LW +: LW] - vb[l*LW +: LW];
    assign vins[l*LW +: LW] = (f_b[1:0] == 2'(l)) ? sa[LW-1:0] : vd[l*LW +: LW];
  end

  always_comb begin
    case (f_b[1:0])
      2'd0:    lane_rd = va[LW-1:0];
      2'd1:    lane_rd = va[2*LW-1:LW];
      2'd2:    lane_rd = va[3*LW-1:2*LW];
      default: lane_rd = '0;
    endcase
  end

  logic          s_we, v_we, m_we;
  logic [DW-1:0] s_val;
  logic [VW-1:0] v_val;

  always_comb begin
    s_we   = 1'b0;
    v_we   = 1'b0;
    m_we   = 1'b0;
    s_val  = '0;
    v_val  = '0;
    halt_n = 1'b0;
    pc_n   = pc_q + 1'b1;
    if (done_q) begin
      pc_n = pc_q;
    end else begin
      case (op)
        OP_ADD:  begin s_we = 1'b1; s_val = sa + sb; end
        OP_SUB:  begin s_we = 1'b1; s_val = sa - sb; end
        OP_LDI:  begin s_we = 1'b1; s_val = DW'(imm); end
        OP_LD:   begin s_we = 1'b1; s_val = dmem[sa]; end
        OP_ST:   m_we = 1'b1;
        OP_VADD: begin v_we = 1'b1; v_val = vsum; end
        OP_VSUB: begin v_we = 1'b1; v_val = vdif; end
        OP_S2L:  begin v_we = (f_b[1:0] != 2'd3); v_val = vins; end
        OP_L2S:  begin s_we = 1'b1; s_val = {{(DW-LW){1'b0}}, lane_rd}; end
        OP_JMP:  pc_n = imem_data[PCW-1:0];
        OP_JZ:   if (sd == '0) pc_n = {pc_q[PCW-1:8], imm};
        OP_HALT: begin pc_n = pc_q; halt_n = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      done_q    <= 1'b0;
      ret_valid <= 1'b0;
      ret_vec   <= 1'b0;
      ret_rd    <= '0;
      ret_val   <= '0;
      for (int i = 0; i < NREG; i++) begin
        sreg[i] <= '0;
        vreg[i] <= '0;
      end
    end else begin
      pc_q      <= pc_n;
      done_q    <= done_q | halt_n;
      ret_valid <= s_we | v_we;
      ret_vec   <= v_we;
      ret_rd    <= f_d;
      ret_val   <= v_we ? v_val : VW'(s_val);
      if (s_we) sreg[f_d] <= s_val;
      if (v_we) vreg[f_d] <= v_val;
    end
  end

  always_ff @(posedge clk) begin
    if (m_we) dmem[sa] <= sd;
  end

  assign imem_addr = pc_q;
  assign done      = done_q;

  // R10
  halt_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (pc_q == $past(pc_q)));
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && op == OP_JMP) |=> (pc_q == $past(imem_data[PCW-1:0])));
  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && op inside {OP_ADD, OP_SUB, OP_LDI, OP_LD, OP_ST, OP_VADD, OP_VSUB, OP_S2L, OP_L2S})
    |=> (pc_q == PCW'($past(pc_q) + 1'b1)));
  // R11
  store_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && op == OP_ST) |=> !ret_valid);
  // R6
  lane3_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && op == OP_S2L && imem_data[1:0] == 2'd3) |=> !ret_valid);
endmodule

// File: tb/vec_core_tb.sv
`timescale 1ns/1ps
module vec_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] imem_addr;
  logic [15:0] imem_data;
  logic        done, ret_valid, ret_vec;
  logic [3:0]  ret_rd;
  logic [14:0] ret_val;

  int checks = 0;
  int errors = 0;

  logic [15:0] rom [256];
  assign imem_data = (imem_addr < 12'd256) ? rom[imem_addr[7:0]] : 16'h0000;

  always #2.5 clk = ~clk;

  vec_core dut_i (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .done(done), .ret_valid(ret_valid), .ret_vec(ret_vec),
    .ret_rd(ret_rd), .ret_val(ret_val)
  );

  // {addr, instr, exp_we, exp_vec, exp_rd, exp_val, exp_next_pc}
  localparam int N = 22;
  localparam logic [60:0] TBL [N] = '{
    {12'h000, 16'h3105, 1'b1, 1'b0, 4'd1, 15'h0005, 12'h001},
    {12'h001, 16'h32FE, 1'b1, 1'b0, 4'd2, 15'h00FE, 12'h002},
    {12'h002, 16'h1312, 1'b1, 1'b0, 4'd3, 15'h0003, 12'h003},
    {12'h003, 16'h2412, 1'b1, 1'b0, 4'd4, 15'h0007, 12'h004},
    {12'h004, 16'h8110, 1'b1, 1'b1, 4'd1, 15'h0005, 12'h005},
    {12'h005, 16'h8122, 1'b1, 1'b1, 4'd1, 15'h7805, 12'h006},
    {12'h006, 16'h351F, 1'b1, 1'b0, 4'd5, 15'h001F, 12'h007},
    {12'h007, 16'h8250, 1'b1, 1'b1, 4'd2, 15'h001F, 12'h008},
    {12'h008, 16'h8251, 1'b1, 1'b1, 4'd2, 15'h03FF, 12'h009},
    {12'h009, 16'h6312, 1'b1, 1'b1, 4'd3, 15'h7BE4, 12'h00A},
    {12'h00A, 16'h7421, 1'b1, 1'b1, 4'd4, 15'h0BFA, 12'h00B},
    {12'h00B, 16'h9632, 1'b1, 1'b0, 4'd6, 15'h001E, 12'h00C},
    {12'h00C, 16'h8313, 1'b0, 1'b0, 4'd0, 15'h0000, 12'h00D},
    {12'h00D, 16'h9730, 1'b1, 1'b0, 4'd7, 15'h0004, 12'h00E},
    {12'h00E, 16'h5120, 1'b0, 1'b0, 4'd0, 15'h0000, 12'h00F},
    {12'h00F, 16'h4820, 1'b1, 1'b0, 4'd8, 15'h0005, 12'h010},
    {12'h010, 16'hB920, 1'b0, 1'b0, 4'd0, 15'h0000, 12'h020},
    {12'h020, 16'hB140, 1'b0, 1'b0, 4'd0, 15'h0000, 12'h021},
    {12'h021, 16'hC000, 1'b0, 1'b0, 4'd0, 15'h0000, 12'h022},
    {12'h022, 16'hA0A5, 1'b0, 1'b0, 4'd0, 15'h0000, 12'h0A5},
    {12'h0A5, 16'h1001, 1'b1, 1'b0, 4'd0, 15'h0005, 12'h0A6},
    {12'h0A6, 16'h0000, 1'b0, 1'b0, 4'd0, 15'h0000, 12'h0A6}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h1, 4'h2, 4'h3: return "R3";
      4'h4, 4'h5:       return "R4";
      4'h6, 4'h7:       return "R5";
      4'h8:             return "R6";
      4'h9:             return "R7";
      4'hA:             return "R8";
      4'hB:             return "R9";
      4'h0:             return "R10";
      default:          return "R2";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    for (int i = 0; i < N; i++) rom[TBL[i][60:49]] = TBL[i][48:33];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset pc", 32'(imem_addr), 32'h0);
    check("R1", "reset done", 32'(done), 32'h0);
    check("R1", "reset ret_valid", 32'(ret_valid), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      logic [60:0] e;
      string r;
      e = TBL[i];
      r = req_of(e[48:45]);
      check("R2", "fetch addr", 32'(imem_addr), 32'(e[60:49]));
      step();
      check("R11", "ret_valid", 32'(ret_valid), 32'(e[32]));
      if (e[32]) begin
        check(r, "ret_vec", 32'(ret_vec), 32'(e[31]));
        check(r, "ret_rd", 32'(ret_rd), 32'(e[30:27]));
        check(r, "ret_val", 32'(ret_val), 32'(e[26:12]));
      end
      check(r, "next pc", 32'(imem_addr), 32'(e[11:0]));
    end

    check("R10", "done after halt", 32'(done), 32'h1);
    repeat (4) step();
    check("R10", "pc frozen", 32'(imem_addr), 32'h0A6);
    check("R10", "done held", 32'(done), 32'h1);
    check("R10", "no commit while halted", 32'(ret_valid), 32'h0);

    rst_n = 1'b0;
    rom[0] = 16'h1312;  // ADD r3,r1,r2
    rom[1] = 16'h9412;  // r4 = V1 lane2
    rom[2] = 16'h6534;  // V5 = V3 + V4
    rom[3] = 16'h9651;  // r6 = V5 lane1
    rom[4] = 16'h0000;
    step();
    check("R1", "reset pc after run", 32'(imem_addr), 32'h0);
    check("R1", "reset clears done", 32'(done), 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R1", "cleared regs commit", 32'(ret_valid), 32'h1);
      check("R1", "cleared regs value", 32'(ret_val), 32'h0);
    end
    step();
    check("R10", "second halt", 32'(done), 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule